// File: doc/BRIEF.md
# Fused Multiply-Add Exception Flag and Writeback Controller

This block sits after a quad-precision fused multiply-add datapath. It computes A × C + B. It receives the condition flags the arithmetic core raised for the current operation. There are three kinds of invalid operation (signaling NaN, infinity times zero, infinity minus infinity), plus overflow, underflow, inexact and fraction-incremented. From these flags the block updates a sticky status and control register. It also decides whether the rounded 128-bit result and its class code are committed. The arithmetic, the rounding and the result classification happen upstream, and their outputs arrive on the input ports.

An operation is presented as a one-cycle `op_valid` strobe. The destination write enable is combinational and is qualified by that strobe, so the register file captures the result on the same edge that updates the status register. A small sequencer then pulses `done` in the following cycle for an executed operation. It pulses `fac_unavail` instead when the vector-scalar facility was disabled. The sequencer has three states: `ST_IDLE`, `ST_DONE` and `ST_FAULT`. The transitions are:

- any state to `ST_DONE` on a strobe with the facility enabled;
- any state to `ST_FAULT` on a strobe with the facility disabled;
- any state to `ST_IDLE` when there is no strobe.

The block also routes operand register indices to the datapath. It chooses the rounding mode handed to the datapath, with a round-to-odd override taking priority over the mode field of the status register. Software can overwrite the whole status register through a write port.

Top module: `fma_exc_wb_ctrl`

## Requirements
- R1: When `op_valid` is high and `fac_en` is low, the operation is refused. The following all hold:
  - `dest_we` stays low;
  - the status register does not change;
  - in the next cycle `fac_unavail` is high and `done` is low.
- R2: On every strobe, the per-operation flag register `op_exc` is cleared and reloaded. After an executed operation it holds exactly that operation's `core_flags`. After a refused operation it holds zero.
- R3: The `core_flags` bit order is {inc, inx, unf, ovf, isi, imz, snan}, from bit 6 down to bit 0. On an executed operation, each flag in bits 5..0 ORs into its own sticky bit of `stat_q`. The sticky bits are: snan at bit 9, imz at bit 10, isi at bit 11, ovf at bit 12, unf at bit 13, inx at bit 14.
- R4: The summary bit `stat_q[15]` is set when an executed operation turns at least one sticky bit from 0 to 1. Raising a flag whose sticky bit is already set leaves the summary bit unchanged.
- R5: A trap condition is (snan | imz | isi) & `inv_en`. During an executed operation with a trap condition, `dest_we` is low and the class field `stat_q[8:4]` keeps its value.
- R6: During an executed operation without a trap condition:
  - `dest_we` is high;
  - `dest_data` equals `res_data`;
  - on the next edge, `stat_q[8:4]` is loaded with `res_class`.
- R7: Every executed operation, trapping or not, loads two status bits:
  - FR `stat_q[3]` with (no invalid flag) & inc;
  - FI `stat_q[2]` with (no invalid flag) & inx.
- R8: `rnd_sel` is 3'b100 when `rto_ovr` is high. Otherwise it is {1'b0, `stat_q[1:0]`}.
- R9: Sticky bits and the summary bit are never cleared by operations. A software write (`sw_we`) replaces the whole status register and wins over an operation update in the same cycle.
- R10: Operand routing is as follows:
  - `mul_a_idx` = `idx_a`;
  - `mul_c_idx` = `idx_b`;
  - both the addend index `add_idx` and `dest_idx` equal `idx_t`.
- R11: `done` is high exactly in the cycle after an executed strobe. Back-to-back strobes keep it high. `dest_we` is never high without `op_valid`.
- R12: After reset the following are all zero: `stat_q`, `op_exc`, `done`, `fac_unavail` and `dest_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| fac_en | input | 1 | Vector-scalar facility enable |
| inv_en | input | 1 | Invalid-operation trap enable |
| core_flags | input | 7 | {inc, inx, unf, ovf, isi, imz, snan} from the core |
| rto_ovr | input | 1 | Round-to-odd override |
| res_data | input | DATA_W | Rounded result |
| res_class | input | 5 | Class code of the result |
| idx_a | input | IDX_W | First multiplicand register index |
| idx_b | input | IDX_W | Second multiplicand register index |
| idx_t | input | IDX_W | Target register index, also the addend |
| sw_we | input | 1 | Software write of the status register |
| sw_data | input | 16 | Software write data |
| rnd_sel | output | 3 | Rounding mode handed to the datapath |
| mul_a_idx | output | IDX_W | Index of multiplicand A |
| mul_c_idx | output | IDX_W | Index of multiplicand C |
| add_idx | output | IDX_W | Index of the addend |
| dest_idx | output | IDX_W | Destination register index |
| dest_we | output | 1 | Destination write enable |
| dest_data | output | DATA_W | Destination write data |
| stat_q | output | 16 | Status and control register |
| op_exc | output | 7 | Flags of the most recent operation |
| done | output | 1 | Completion pulse |
| fac_unavail | output | 1 | Facility-unavailable exception pulse |

## Verification
The assertions check the following on every cycle:
- the write-enable rules around traps, refused operations and clean operations;
- the quieting of FR and FI under invalid flags;
- the monotonic behaviour of the sticky bits between software writes;
- the rounding-select priority;
- the pulse relationship of `done` and `fac_unavail` to the strobe.

Only the bench scenarios can show:
- the exact per-bit mapping of each flag into the status register;
- the summary bit staying clear when a flag is raised whose sticky bit is already set;
- the class field being retained across a trap;
- the per-operation flag register being cleared;
- the precedence of a software write that coincides with an operation.

// File: rtl/fma_exc_pkg.sv
package fma_exc_pkg;

    // Status register layout
    localparam int STAT_W  = 16;
    localparam int RN_LSB  = 0;
    localparam int RN_W    = 2;
    localparam int FI_BIT  = 2;
    localparam int FR_BIT  = 3;
    localparam int CLS_LSB = 4;
    localparam int CLS_W   = 5;
    localparam int STK_LSB = 9;
    localparam int STK_N   = 6;
    localparam int FX_BIT  = 15;
    localparam int FLAG_W  = 7;

    localparam logic [2:0] RSEL_ODD = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic inc;
        logic inx;
        logic unf;
        logic ovf;
        logic isi;
        logic imz;
        logic snan;
    } core_flags_t;

endpackage

// File: rtl/fma_exc_decode.sv
module fma_exc_decode
    import fma_exc_pkg::*;
(
    input  logic               op_valid,
    input  logic               fac_en,
    input  logic               inv_en,
    input  core_flags_t        flags,
    input  logic               rto_ovr,
    input  logic [RN_W-1:0]    rn_field,
    output logic               exec,
    output logic               refuse,
    output logic               wr_ok,
    output logic [STK_N-1:0]   sets,
    output logic               fr_new,
    output logic               fi_new,
    output logic [2:0]         rnd_sel
);

    logic any_invalid;
    logic trap;

    always_comb begin
        any_invalid = flags.snan | flags.imz | flags.isi;
        trap        = any_invalid & inv_en;
        exec        = op_valid & fac_en;
        refuse      = op_valid & ~fac_en;
        wr_ok       = exec & ~trap;
        sets        = {flags.inx, flags.unf, flags.ovf,
                       flags.isi, flags.imz, flags.snan};
        fr_new      = ~any_invalid & flags.inc;
        fi_new      = ~any_invalid & flags.inx;
        if (rto_ovr) begin
            rnd_sel = RSEL_ODD;
        end else begin
            rnd_sel = {1'b0, rn_field};
        end
    end

endmodule

// File: rtl/fma_exc_statreg.sv
module fma_exc_statreg
    import fma_exc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exec,
    input  logic                refuse,
    input  logic                sw_we,
    input  logic [STAT_W-1:0]   sw_data,
    input  logic [STK_N-1:0]    sets,
    input  logic                fr_new,
    input  logic                fi_new,
    input  logic                cls_we,
    input  logic [CLS_W-1:0]    cls,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic [STAT_W-1:0]   stat,
    output logic [FLAG_W-1:0]   op_exc
);

    logic [STAT_W-1:0] stat_r;
    logic [STAT_W-1:0] stat_nxt;
    logic [STK_N-1:0]  stk_old;
    logic [STK_N-1:0]  fresh;
    logic [FLAG_W-1:0] exc_r;

    always_comb begin
        stk_old  = stat_r[STK_LSB +: STK_N];
        fresh    = sets & ~stk_old;
        stat_nxt = stat_r;
        if (exec) begin
            stat_nxt[STK_LSB +: STK_N] = stk_old | sets;
            if (|fresh) begin
                stat_nxt[FX_BIT] = 1'b1;
            end
            stat_nxt[FR_BIT] = fr_new;
            stat_nxt[FI_BIT] = fi_new;
            if (cls_we) begin
                stat_nxt[CLS_LSB +: CLS_W] = cls;
            end
        end
        if (sw_we) begin
            stat_nxt = sw_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_r <= '0;
        end else begin
            stat_r <= stat_nxt;
        end
    end

    // Per-operation flags: cleared at every strobe, then loaded if executed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_r <= '0;
        end else if (exec) begin
            exc_r <= flags_in;
        end else if (refuse) begin
            exc_r <= '0;
        end
    end

    assign stat   = stat_r;
    assign op_exc = exc_r;

endmodule

// File: rtl/fma_exc_seq.sv
module fma_exc_seq
    import fma_exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exec,
    input  logic refuse,
    output logic done,
    output logic fac_unavail
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (exec) begin
                    state_d = ST_DONE;
                end else if (refuse) begin
                    state_d = ST_FAULT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done        = 1'b0;
        fac_unavail = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DONE:  done = 1'b1;
            ST_FAULT: fac_unavail = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/fma_exc_wb_ctrl.sv
module fma_exc_wb_ctrl
    import fma_exc_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic                fac_en,
    input  logic                inv_en,
    input  logic [6:0]          core_flags,
    input  logic                rto_ovr,
    input  logic [DATA_W-1:0]   res_data,
    input  logic [4:0]          res_class,
    input  logic [IDX_W-1:0]    idx_a,
    input  logic [IDX_W-1:0]    idx_b,
    input  logic [IDX_W-1:0]    idx_t,
    input  logic                sw_we,
    input  logic [15:0]         sw_data,
    output logic [2:0]          rnd_sel,
    output logic [IDX_W-1:0]    mul_a_idx,
    output logic [IDX_W-1:0]    mul_c_idx,
    output logic [IDX_W-1:0]    add_idx,
    output logic [IDX_W-1:0]    dest_idx,
    output logic                dest_we,
    output logic [DATA_W-1:0]   dest_data,
    output logic [15:0]         stat_q,
    output logic [6:0]          op_exc,
    output logic                done,
    output logic                fac_unavail
);

    core_flags_t        flags;
    logic               exec;
    logic               refuse;
    logic               wr_ok;
    logic [STK_N-1:0]   sets;
    logic               fr_new;
    logic               fi_new;
    logic [STAT_W-1:0]  stat;

    assign flags = core_flags_t'(core_flags);

    fma_exc_decode u_decode (
        .op_valid (op_valid),
        .fac_en   (fac_en),
        .inv_en   (inv_en),
        .flags    (flags),
        .rto_ovr  (rto_ovr),
        .rn_field (stat[RN_LSB +: RN_W]),
        .exec     (exec),
        .refuse   (refuse),
        .wr_ok    (wr_ok),
        .sets     (sets),
        .fr_new   (fr_new),
        .fi_new   (fi_new),
        .rnd_sel  (rnd_sel)
    );

    fma_exc_statreg u_statreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec     (exec),
        .refuse   (refuse),
        .sw_we    (sw_we),
        .sw_data  (sw_data),
        .sets     (sets),
        .fr_new   (fr_new),
        .fi_new   (fi_new),
        .cls_we   (wr_ok),
        .cls      (res_class),
        .flags_in (core_flags),
        .stat     (stat),
        .op_exc   (op_exc)
    );

    fma_exc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec        (exec),
        .refuse      (refuse),
        .done        (done),
        .fac_unavail (fac_unavail)
    );

    // Operand routing: multiply A by C, add the target's old value
    assign mul_a_idx = idx_a;
    assign mul_c_idx = idx_b;
    assign add_idx   = idx_t;
    assign dest_idx  = idx_t;

    assign dest_we   = wr_ok;
    assign dest_data = res_data;
    assign stat_q    = stat;

endmodule

// File: rtl/fma_exc_chk.sv
module fma_exc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        fac_en,
    input logic        inv_en,
    input logic [6:0]  core_flags,
    input logic        rto_ovr,
    input logic        sw_we,
    input logic [2:0]  rnd_sel,
    input logic        dest_we,
    input logic [15:0] stat_q,
    input logic        done,
    input logic        fac_unavail
);

    localparam logic [15:0] HOLD_MASK = 16'hFE00;

    assert_trap_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fac_en && inv_en && (core_flags[2:0] != 3'b000)) |-> !dest_we);

    assert_clean_op_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fac_en && !(inv_en && (core_flags[2:0] != 3'b000))) |-> dest_we);

    assert_refused_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fac_en) |-> !dest_we);

    assert_refused_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fac_en) |=> (fac_unavail && !done));

    assert_refused_keeps_stat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fac_en && !sw_we) |=> (stat_q == $past(stat_q)));

    assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fac_en) |=> (done && !fac_unavail));

    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!done && !fac_unavail));

    assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !dest_we);

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((stat_q & $past(stat_q) & HOLD_MASK) == ($past(stat_q) & HOLD_MASK)));

    assert_fr_fi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && fac_en && !sw_we && (core_flags[2:0] != 3'b000)) |=> (!stat_q[3] && !stat_q[2]));

    assert_odd_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rto_ovr |-> (rnd_sel == 3'b100));

    assert_mode_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rto_ovr |-> (rnd_sel == {1'b0, stat_q[1:0]}));

endmodule

bind fma_exc_wb_ctrl fma_exc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .fac_en      (fac_en),
    .inv_en      (inv_en),
    .core_flags  (core_flags),
    .rto_ovr     (rto_ovr),
    .sw_we       (sw_we),
    .rnd_sel     (rnd_sel),
    .dest_we     (dest_we),
    .stat_q      (stat_q),
    .done        (done),
    .fac_unavail (fac_unavail)
);

// File: tb/tb_fma_exc_wb_ctrl.sv
`timescale 1ns/1ps
module tb_fma_exc_wb_ctrl;

    localparam int DATA_W = 128;
    localparam int IDX_W  = 5;
    localparam int NVEC   = 16;
    localparam logic [15:0] PRESET = 16'h01F2;

    // {fac_en, inv_en, rto_ovr, flags{inc,inx,unf,ovf,isi,imz,snan}}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b100_0000000, 10'b100_0000001, 10'b110_0000001, 10'b110_0000010,
        10'b110_0000100, 10'b100_0001000, 10'b100_0010000, 10'b110_0100000,
        10'b110_1000000, 10'b110_1100000, 10'b110_1100001, 10'b100_1100100,
        10'b010_0000111, 10'b101_0111000, 10'b001_1111111, 10'b111_0111110
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic              fac_en = 1'b0;
    logic              inv_en = 1'b0;
    logic [6:0]        core_flags = '0;
    logic              rto_ovr = 1'b0;
    logic [DATA_W-1:0] res_data = '0;
    logic [4:0]        res_class = '0;
    logic [IDX_W-1:0]  idx_a = '0;
    logic [IDX_W-1:0]  idx_b = '0;
    logic [IDX_W-1:0]  idx_t = '0;
    logic              sw_we = 1'b0;
    logic [15:0]       sw_data = '0;
    logic [2:0]        rnd_sel;
    logic [IDX_W-1:0]  mul_a_idx;
    logic [IDX_W-1:0]  mul_c_idx;
    logic [IDX_W-1:0]  add_idx;
    logic [IDX_W-1:0]  dest_idx;
    logic              dest_we;
    logic [DATA_W-1:0] dest_data;
    logic [15:0]       stat_q;
    logic [6:0]        op_exc;
    logic              done;
    logic              fac_unavail;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fma_exc_wb_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fac_en(fac_en),
        .inv_en(inv_en), .core_flags(core_flags), .rto_ovr(rto_ovr),
        .res_data(res_data), .res_class(res_class), .idx_a(idx_a),
        .idx_b(idx_b), .idx_t(idx_t), .sw_we(sw_we), .sw_data(sw_data),
        .rnd_sel(rnd_sel), .mul_a_idx(mul_a_idx), .mul_c_idx(mul_c_idx),
        .add_idx(add_idx), .dest_idx(dest_idx), .dest_we(dest_we),
        .dest_data(dest_data), .stat_q(stat_q), .op_exc(op_exc),
        .done(done), .fac_unavail(fac_unavail)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_stat(input logic [15:0] old, input logic fac,
                                               input logic inv, input logic [6:0] fl,
                                               input logic [4:0] cls);
        logic [15:0] n;
        logic [5:0]  fresh;
        logic        vx;
        n = old;
        if (fac) begin
            fresh    = fl[5:0] & ~old[14:9];
            n[14:9]  = old[14:9] | fl[5:0];
            if (|fresh) n[15] = 1'b1;
            vx       = |fl[2:0];
            n[3]     = ~vx & fl[6];
            n[2]     = ~vx & fl[5];
            if (!(vx && inv)) n[8:4] = cls;
        end
        return n;
    endfunction

    task automatic sw_write(input logic [15:0] v);
        @(negedge clk);
        sw_we = 1'b1;
        sw_data = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // Drive one operation; leaves the bench at the negedge after the capturing edge
    task automatic do_op(input logic fac, input logic inv, input logic [6:0] fl,
                         input logic [4:0] cls, input logic [127:0] data);
        @(negedge clk);
        op_valid = 1'b1; fac_en = fac; inv_en = inv; core_flags = fl;
        res_class = cls; res_data = data;
        @(negedge clk);
        op_valid = 1'b0; core_flags = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] exp_s;
        logic        exp_we;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(stat_q == 16'h0, "R12 stat", stat_q, 0);
        check(op_exc == 7'h0, "R12 op_exc", op_exc, 0);
        check(!done && !fac_unavail, "R12 pulses", {done, fac_unavail}, 0);
        check(!dest_we, "R12 dest_we", dest_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] v;
            v = VEC[i];
            sw_write(PRESET);
            @(negedge clk);
            op_valid = 1'b1; fac_en = v[9]; inv_en = v[8]; rto_ovr = v[7];
            core_flags = v[6:0]; res_class = 5'(i);
            res_data = {8{16'hA500 + 16'(i)}};
            #1;
            exp_we = v[9] & ~(v[8] & |v[2:0]);
            check(dest_we == exp_we, "R5/R6/R1 dest_we", dest_we, exp_we);
            if (exp_we) check(dest_data == res_data, "R6 dest_data", dest_data, res_data);
            check(rnd_sel == (v[7] ? 3'b100 : 3'b010), "R8 rnd_sel", rnd_sel,
                  v[7] ? 3'b100 : 3'b010);
            exp_s = model_stat(PRESET, v[9], v[8], v[6:0], 5'(i));
            @(negedge clk);
            op_valid = 1'b0; core_flags = '0; rto_ovr = 1'b0;
            check(stat_q == exp_s, "R3/R4/R5/R7 stat", stat_q, exp_s);
            check(done == v[9], "R11 done", done, v[9]);
            check(fac_unavail == ~v[9], "R1 fac_unavail", fac_unavail, ~v[9]);
            check(op_exc == (v[9] ? v[6:0] : 7'h0), "R2 op_exc", op_exc,
                  v[9] ? v[6:0] : 7'h0);
        end

        // R4: re-raising an already sticky flag leaves FX clear
        sw_write(16'h0200);
        do_op(1'b1, 1'b0, 7'b0000001, 5'h3, '1);
        check(stat_q[15] == 1'b0, "R4 fx stays clear", stat_q[15], 0);
        check(stat_q[9] == 1'b1, "R3 snan sticky", stat_q[9], 1);
        do_op(1'b1, 1'b0, 7'b0001000, 5'h3, '1);
        check(stat_q[15] == 1'b1, "R4 fx on new sticky", stat_q[15], 1);
        check(stat_q[12] == 1'b1, "R3 ovf sticky", stat_q[12], 1);

        // R9: sticky bits survive a clean operation
        do_op(1'b1, 1'b0, 7'b0000000, 5'h4, '1);
        check((stat_q & 16'hFE00) == 16'h9200, "R9 sticky hold", stat_q & 16'hFE00, 16'h9200);
        // R2: flags cleared by the next operation
        do_op(1'b1, 1'b0, 7'b0110000, 5'h4, '1);
        check(op_exc == 7'b0110000, "R2 op_exc load", op_exc, 7'b0110000);
        do_op(1'b1, 1'b0, 7'b0000000, 5'h4, '1);
        check(op_exc == 7'h0, "R2 op_exc cleared", op_exc, 0);

        // R9: software write wins over a coincident operation
        @(negedge clk);
        op_valid = 1'b1; fac_en = 1'b1; inv_en = 1'b0; core_flags = 7'b0010000;
        sw_we = 1'b1; sw_data = 16'h0043;
        @(negedge clk);
        op_valid = 1'b0; sw_we = 1'b0; core_flags = '0;
        check(stat_q == 16'h0043, "R9 sw priority", stat_q, 16'h0043);
        // R8: mode field from software write
        #1;
        check(rnd_sel == 3'b011, "R8 mode field", rnd_sel, 3'b011);

        // R10: operand routing
        idx_a = 5'd7; idx_b = 5'd19; idx_t = 5'd30;
        #1;
        check(mul_a_idx == 5'd7 && mul_c_idx == 5'd19, "R10 mul idx",
              {mul_a_idx, mul_c_idx}, {5'd7, 5'd19});
        check(add_idx == 5'd30 && dest_idx == 5'd30, "R10 addend/dest idx",
              {add_idx, dest_idx}, {5'd30, 5'd30});

        // R11: back-to-back strobes keep done high, then it drops
        @(negedge clk);
        op_valid = 1'b1; fac_en = 1'b1;
        @(negedge clk);
        check(done, "R11 done first", done, 1);
        @(negedge clk);
        op_valid = 1'b0;
        check(done, "R11 done second", done, 1);
        @(negedge clk);
        check(!done && !dest_we, "R11 idle", {done, dest_we}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule